// File: doc/BRIEF.md
# Pulse-Disciplined Wall Clock Unit

This block keeps wall-clock time aligned to an external timing pulse that arrives about once every two seconds. An asynchronous pulse input is synchronized and edge-detected. Each qualified edge restarts a fine counter that runs on the sample clock, advances a pulse counter and raises an interrupt. On the first qualified edge after enabling, the block copies the time presented by the time source (`ref_sec_i`, `ref_nsec_i`) into two base-time registers. Software rebuilds the present time as base time, plus two seconds for each pulse after the first, plus the fine count divided by the sample rate.

To read coarse and fine time as one coherent pair, software reads the pulse count first. That same read copies the live fine counter into a snapshot register, which software then reads at leisure. All six registers are 32 bits wide and can be both read and written over a simple one-cycle register bus.

A three-state controller sequences the block. In `WC_OFF` the counters are held at zero and pulses are ignored. `WC_ARMED` waits for the epoch pulse. `WC_LOCKED` is normal running with the base registers frozen. The transitions are:
- `WC_OFF` to `WC_ARMED` when the enable bit is set.
- `WC_ARMED` to `WC_LOCKED` on a qualified pulse, which captures the base time.
- Either `WC_ARMED` or `WC_LOCKED` back to `WC_OFF` when the enable bit is cleared, which re-arms the capture.

Top module: `wclk_unit`

## Requirements
- R1: A rising transition of `sync_pulse_in` acts exactly once, however long the input stays high. Its effects on the counters and the interrupt are registered on the third rising clock edge after the input changes: two synchronizer flops, then the edge detector.
- R2: While enabled, the fine counter (offset 0x2C) advances by one every clock. A qualified pulse sets it to zero, after which it counts up from zero again.
- R3: If pulses stop arriving, the fine counter counts up to 0xFFFFFFFF and then holds that value; it does not wrap.
- R4: The pulse counter (offset 0x24) counts every qualified pulse, including the first (epoch) pulse, and wraps modulo 2^32.
- R5: A bus read of the pulse counter copies the fine counter value from that same cycle into the snapshot register (offset 0x28). The snapshot keeps that value until the next such read or a write to it.
- R6: On the first qualified pulse in `WC_ARMED`, `ref_sec_i` is copied into base seconds (0x14) and `ref_nsec_i` into base nanoseconds (0x18), bit for bit. In the nanosecond word, bits [5:0] are the leap-second count and bits [31:6] are nanoseconds divided by 16. Later pulses leave both registers unchanged.
- R7: Control bit 0 (offset 0x20) enables the block. While it is clear, both counters read zero, writes to the counters have no effect, and pulses neither count, capture nor interrupt. Setting it again re-arms the base capture.
- R8: `irq_o` rises on the clock edge that registers a qualified pulse and stays high until a write to control with bit 1 set. Bit 1 is a strobe and reads back as 0. If a pulse and a clear land in the same cycle, the pulse wins.
- R9: Each of the six registers takes a bus write. A write to a counter takes precedence over counting and restart in the same cycle. Read data appears on `bus_rdata_o` one clock after `bus_rd_i`. Unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock for all logic |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_pulse_in | input | 1 | Asynchronous discipline pulse from the time source |
| ref_sec_i | input | 32 | Seconds value presented by the time source for the epoch pulse |
| ref_nsec_i | input | 32 | Packed nanosecond/leap value presented for the epoch pulse |
| bus_addr_i | input | 8 | Byte offset of the register accessed |
| bus_wr_i | input | 1 | Write strobe, one cycle |
| bus_rd_i | input | 1 | Read strobe, one cycle |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid one cycle after the read strobe |
| irq_o | output | 1 | Level interrupt, set by each qualified pulse |

## Verification
The fine counter is sampled at several known distances from a pulse. This separates an off-by-one in the synchronizer latency from a counter that fails to restart. A long high level on the pulse input is contrasted with a short one, which shows whether edge detection or level sensing drives the count. A second pulse that arrives with a different reference time shows whether the base registers are frozen after the epoch. A disable and re-enable shows that the capture is re-armed. Preloading the counters near all-ones exercises saturation of the fine counter and wrapping of the pulse counter. Reading the pulse count and then the snapshot at different times checks that the pair is latched in the same cycle.

// File: rtl/wclk_pkg.sv
package wclk_pkg;

    typedef enum logic [1:0] {
        WC_OFF    = 2'd0,
        WC_ARMED  = 2'd1,
        WC_LOCKED = 2'd2
    } wc_state_e;

    localparam int unsigned BUS_AW = 8;

    localparam logic [BUS_AW-1:0] OFS_BASE_SEC  = 8'h14;
    localparam logic [BUS_AW-1:0] OFS_BASE_NSEC = 8'h18;
    localparam logic [BUS_AW-1:0] OFS_CTRL      = 8'h20;
    localparam logic [BUS_AW-1:0] OFS_PULSES    = 8'h24;
    localparam logic [BUS_AW-1:0] OFS_SNAP      = 8'h28;
    localparam logic [BUS_AW-1:0] OFS_FINE      = 8'h2C;

    localparam int unsigned CTRL_RUN_BIT = 0;
    localparam int unsigned CTRL_ACK_BIT = 1;

endpackage

// File: rtl/wclk_pulse_sync.sv
module wclk_pulse_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_o
);
    localparam int unsigned CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[CHAIN_W-2:0], async_in};
    end

    assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];

    // R1: a single edge yields a single-cycle event
    a_r1_single_event: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/wclk_fine_counter.sv
module wclk_fine_counter #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         restart,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (!rst_n || !en)    cnt_o <= '0;
        else if (ld)          cnt_o <= ld_val;
        else if (restart)     cnt_o <= '0;
        else if (cnt_o != TOP) cnt_o <= cnt_o + 1'b1;
    end

    a_r2_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (en && restart && !ld) |=> (cnt_o == '0));

    a_r3_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !restart && !ld && cnt_o == TOP) |=> (cnt_o == TOP));
endmodule

// File: rtl/wclk_pulse_counter.sv
module wclk_pulse_counter #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         step,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] cnt_o
);
    always_ff @(posedge clk) begin
        if (!rst_n || !en) cnt_o <= '0;
        else if (ld)       cnt_o <= ld_val;
        else if (step)     cnt_o <= cnt_o + 1'b1;
    end

    a_r4_step_once: assert property (@(posedge clk) disable iff (!rst_n)
        (en && step && !ld) |=> (cnt_o == W'($past(cnt_o) + 1'b1)));
endmodule

// File: rtl/wclk_unit.sv
module wclk_unit
    import wclk_pkg::*;
#(
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_pulse_in,
    input  logic [DATA_W-1:0] ref_sec_i,
    input  logic [DATA_W-1:0] ref_nsec_i,
    input  logic [BUS_AW-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o
);
    wc_state_e state_q, state_nx;

    logic              pulse_rise;
    logic              run_q;
    logic              cnt_en;
    logic              pulse_ok;
    logic [DATA_W-1:0] fine_cnt, pulse_cnt;
    logic [DATA_W-1:0] base_sec_q, base_nsec_q, snap_q;

    logic wr_ctrl, wr_bsec, wr_bnsec, wr_pulses, wr_snap, wr_fine;
    logic rd_pulses;

    assign wr_ctrl   = bus_wr_i && (bus_addr_i == OFS_CTRL);
    assign wr_bsec   = bus_wr_i && (bus_addr_i == OFS_BASE_SEC);
    assign wr_bnsec  = bus_wr_i && (bus_addr_i == OFS_BASE_NSEC);
    assign wr_pulses = bus_wr_i && (bus_addr_i == OFS_PULSES);
    assign wr_snap   = bus_wr_i && (bus_addr_i == OFS_SNAP);
    assign wr_fine   = bus_wr_i && (bus_addr_i == OFS_FINE);
    assign rd_pulses = bus_rd_i && (bus_addr_i == OFS_PULSES);

    assign cnt_en   = (state_q != WC_OFF);
    assign pulse_ok = pulse_rise && cnt_en;

    wclk_pulse_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (sync_pulse_in),
        .rise_o   (pulse_rise)
    );

    wclk_fine_counter #(.W(DATA_W)) u_fine (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (cnt_en),
        .restart (pulse_rise),
        .ld      (wr_fine),
        .ld_val  (bus_wdata_i),
        .cnt_o   (fine_cnt)
    );

    wclk_pulse_counter #(.W(DATA_W)) u_pulses (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (cnt_en),
        .step   (pulse_rise),
        .ld     (wr_pulses),
        .ld_val (bus_wdata_i),
        .cnt_o  (pulse_cnt)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WC_OFF;
        else        state_q <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            WC_OFF:    if (run_q) state_nx = WC_ARMED;
            WC_ARMED:  if (!run_q) state_nx = WC_OFF;
                       else if (pulse_rise) state_nx = WC_LOCKED;
            WC_LOCKED: if (!run_q) state_nx = WC_OFF;
            default:   state_nx = WC_OFF;
        endcase
    end

    // registered outputs and register file
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q       <= 1'b0;
            irq_o       <= 1'b0;
            base_sec_q  <= '0;
            base_nsec_q <= '0;
            snap_q      <= '0;
            bus_rdata_o <= '0;
        end else begin
            if (wr_ctrl) run_q <= bus_wdata_i[CTRL_RUN_BIT];

            if (pulse_ok)                               irq_o <= 1'b1;
            else if (wr_ctrl && bus_wdata_i[CTRL_ACK_BIT]) irq_o <= 1'b0;

            if (state_q == WC_ARMED && pulse_rise) begin
                base_sec_q  <= ref_sec_i;
                base_nsec_q <= ref_nsec_i;
            end else begin
                if (wr_bsec)  base_sec_q  <= bus_wdata_i;
                if (wr_bnsec) base_nsec_q <= bus_wdata_i;
            end

            if (rd_pulses)    snap_q <= fine_cnt;
            else if (wr_snap) snap_q <= bus_wdata_i;

            if (bus_rd_i) begin
                unique case (bus_addr_i)
                    OFS_BASE_SEC:  bus_rdata_o <= base_sec_q;
                    OFS_BASE_NSEC: bus_rdata_o <= base_nsec_q;
                    OFS_CTRL:      bus_rdata_o <= DATA_W'(run_q);
                    OFS_PULSES:    bus_rdata_o <= pulse_cnt;
                    OFS_SNAP:      bus_rdata_o <= snap_q;
                    OFS_FINE:      bus_rdata_o <= fine_cnt;
                    default:       bus_rdata_o <= '0;
                endcase
            end
        end
    end

    // R5: snapshot pairs with the pulse-count read of the same cycle
    a_r5_snap_pair: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pulses |=> (snap_q == $past(fine_cnt)));

    // R6: base time frozen once locked
    a_r6_base_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WC_LOCKED && !wr_bsec && !wr_bnsec)
        |=> ($stable(base_sec_q) && $stable(base_nsec_q)));

    // R7: counters read zero while off
    a_r7_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WC_OFF) |=> (fine_cnt == '0 && pulse_cnt == '0));

    // R8: interrupt set by a qualified pulse
    a_r8_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_ok |=> irq_o);

    // R8: interrupt held until acknowledged
    a_r8_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !(wr_ctrl && bus_wdata_i[CTRL_ACK_BIT])) |=> irq_o);
endmodule

// File: tb/sim_wclk_unit.sv
module sim_wclk_unit;
    localparam int CLK_PERIOD = 10;

    localparam logic [7:0] A_BSEC  = 8'h14;
    localparam logic [7:0] A_BNSEC = 8'h18;
    localparam logic [7:0] A_CTRL  = 8'h20;
    localparam logic [7:0] A_PCNT  = 8'h24;
    localparam logic [7:0] A_SNAP  = 8'h28;
    localparam logic [7:0] A_FINE  = 8'h2C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_pulse_in = 1'b0;
    logic [31:0] ref_sec = '0;
    logic [31:0] ref_nsec = '0;
    logic [7:0]  addr = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int tests = 0;
    int fails = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wclk_unit u0 (
        .clk(clk), .rst_n(rst_n), .sync_pulse_in(sync_pulse_in),
        .ref_sec_i(ref_sec), .ref_nsec_i(ref_nsec),
        .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
    );

    // monitor: pops one expected item per completed read
    always @(posedge clk) rd_seen <= rd;

    always @(negedge clk) begin
        if (rd_seen) begin
            tests++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL read with no expectation: got %h", rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rdata !== e) begin
                    fails++;
                    $display("FAIL %s: got %h expected %h", t, rdata, e);
                end
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        addr = a; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic fire_pulse();
        sync_pulse_in = 1'b1;
        idle(3);
        sync_pulse_in = 1'b0;
    endtask

    task automatic check_irq(input logic e, input string t);
        tests++;
        if (irq !== e) begin
            fails++;
            $display("FAIL %s: irq got %b expected %b", t, irq, e);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired: got hang expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        ref_sec  = 32'h1000_0000;
        ref_nsec = {26'd12345, 6'd18};
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // reset state
        check_irq(1'b0, "R8 reset irq");
        bus_read(A_CTRL, 32'd0, "R7 reset ctrl");
        bus_read(A_PCNT, 32'd0, "R4 reset pulse count");
        bus_read(A_FINE, 32'd0, "R7 reset fine");

        // pulse while disabled is ignored
        fire_pulse();
        idle(2);
        check_irq(1'b0, "R7 no irq while off");
        bus_read(A_PCNT, 32'd0, "R7 no count while off");
        bus_read(A_BSEC, 32'd0, "R7 no capture while off");

        // enable and take the epoch pulse
        bus_write(A_CTRL, 32'd1);
        idle(2);
        bus_read(A_CTRL, 32'd1, "R9 ctrl readback");
        fire_pulse();
        bus_read(A_FINE, 32'd0, "R1 R2 fine restarts on third edge");
        check_irq(1'b1, "R8 irq on pulse");
        bus_read(A_FINE, 32'd1, "R2 fine advances");
        idle(5);
        bus_read(A_FINE, 32'd7, "R2 fine after gap");
        bus_read(A_PCNT, 32'd1, "R4 epoch pulse counted");
        bus_read(A_SNAP, 32'd8, "R5 snapshot paired with count read");
        bus_read(A_BSEC, 32'h1000_0000, "R6 base seconds captured");
        bus_read(A_BNSEC, {26'd12345, 6'd18}, "R6 base nsec with leap field");
        idle(20);
        bus_read(A_SNAP, 32'd8, "R5 snapshot held");
        bus_read(A_PCNT, 32'd1, "R4 count steady");
        bus_read(A_SNAP, 32'd33, "R5 snapshot relatched");

        // interrupt acknowledge
        check_irq(1'b1, "R8 irq held");
        bus_write(A_CTRL, 32'd3);
        check_irq(1'b0, "R8 irq cleared by ack");
        bus_read(A_CTRL, 32'd1, "R8 ack bit reads zero");

        // later pulse leaves base time alone
        ref_sec = 32'hDEAD_0001;
        fire_pulse();
        bus_read(A_PCNT, 32'd2, "R4 second pulse counted");
        bus_read(A_SNAP, 32'd0, "R5 snapshot right after pulse");
        bus_read(A_BSEC, 32'h1000_0000, "R6 base frozen after epoch");
        check_irq(1'b1, "R8 irq on second pulse");

        // long high level counts once
        sync_pulse_in = 1'b1;
        idle(12);
        sync_pulse_in = 1'b0;
        idle(4);
        bus_read(A_PCNT, 32'd3, "R1 held level counts once");
        bus_write(A_CTRL, 32'd3);

        // saturation of the fine counter
        bus_write(A_FINE, 32'hFFFF_FFFC);
        idle(6);
        bus_read(A_FINE, 32'hFFFF_FFFF, "R3 fine saturates");
        idle(3);
        bus_read(A_FINE, 32'hFFFF_FFFF, "R3 fine stays saturated");

        // write access and precedence
        bus_write(A_FINE, 32'd100);
        bus_read(A_FINE, 32'd100, "R9 fine write wins over count");
        bus_write(A_PCNT, 32'hFFFF_FFFF);
        fire_pulse();
        bus_read(A_PCNT, 32'd0, "R4 pulse count wraps");
        bus_write(A_BSEC, 32'h55);
        bus_read(A_BSEC, 32'h55, "R9 base seconds writable");
        bus_write(A_SNAP, 32'h77);
        bus_read(A_SNAP, 32'h77, "R9 snapshot writable");
        bus_read(8'h00, 32'd0, "R9 unmapped reads zero");

        // disable: ack and stop together
        bus_write(A_CTRL, 32'd2);
        check_irq(1'b0, "R8 ack with disable");
        idle(3);
        bus_read(A_FINE, 32'd0, "R7 fine zero when off");
        bus_read(A_PCNT, 32'd0, "R7 pulses zero when off");
        bus_write(A_FINE, 32'd5);
        bus_read(A_FINE, 32'd0, "R7 fine write ignored when off");
        ref_sec  = 32'hCAFE_0002;
        ref_nsec = {26'd777, 6'd3};
        fire_pulse();
        idle(1);
        check_irq(1'b0, "R7 pulse ignored when off");
        bus_read(A_BSEC, 32'h55, "R7 no capture when off");

        // re-arm captures again
        bus_write(A_CTRL, 32'd1);
        idle(2);
        fire_pulse();
        bus_read(A_PCNT, 32'd1, "R7 count restarts after re-arm");
        bus_read(A_BSEC, 32'hCAFE_0002, "R6 R7 recapture after re-arm");
        bus_read(A_BNSEC, {26'd777, 6'd3}, "R6 R7 nsec recapture");
        idle(2);

        if (exp_q.size() != 0) begin
            tests++;
            fails++;
            $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule